// File: doc/BRIEF.md
# Signaling Change-of-State Detector

This block watches the received robbed-bit or channel-associated signaling of a framed T1 or E1 line and reports when any channel's four-bit signaling state moves. Signaling samples arrive as a stream of (channel, nibble) pairs. Each pair is held in a staging buffer. When the multiframe strobe pulses, the staged nibble of every active channel is copied at once into a readable bank. It is also compared against the last state that was reported for that channel.

A difference sets that channel's sticky change flag, whatever its enable bit says. The per-channel enable bits only decide whether the change also sets the summary status bit. The summary bit drives the interrupt request when the interrupt enable is set. A separate sticky bit marks every multiframe boundary so software knows when the bank is fresh. An optional global integration mode suppresses short glitches: a new value must be seen at three consecutive boundaries before it is reported. All sticky bits are write-one-to-clear. A set in the same cycle wins over a clear.

The ingress stream never applies back-pressure. `s_ready` is held high, so every cycle with `s_valid` high transfers one sample. A sample whose channel index is outside the active range is accepted and discarded. Framing recovery and pulling signaling bits out of the line are done upstream.

Top module: `sigcos_top`

## Requirements
- R1: `s_ready` is always 1. A cycle with `s_valid` high and `s_chan` below the active channel count writes `s_nib` into that channel's staging entry. A sample with any other channel index changes no state.
- R2: The readable nibble of an active channel changes only on a cycle with `mf_strobe` high. It then takes the staging value held before that cycle. A sample accepted in the strobe cycle belongs to the next multiframe. Staging entries keep their value until they are rewritten.
- R3: `mf_status` is set one cycle after each `mf_strobe` and cleared by `clr_mf`. A strobe in the same cycle as the clear leaves it set.
- R4: The first strobe after reset loads each active channel's reference state and sets no change flag.
- R5: With `integ_en` low, a strobe sets `chg_flags[c]` when channel c's new nibble differs from its reference in any of the 4 bits. The flag is set whatever `chan_en[c]` holds. The reference then takes the new nibble.
- R6: Each bit of `chg_flags` stays set until the matching bit of `clr_chg` is written as 1. A set in the same cycle as its clear leaves the bit set.
- R7: `cos_status` is set at a strobe that sets at least one change flag whose `chan_en` bit is 1. It is cleared by `clr_cos`, and a set wins over a clear in the same cycle.
- R8: `irq` equals `cos_status` AND `irq_en`, with no added delay.
- R9: With `integ_en` high, a channel's flag sets only at the third consecutive strobe that brings the same new value differing from the reference. A value present for one or two strobes sets nothing.
- R10: `e1_mode` = 0 makes channels 0 to 23 active, and `e1_mode` = 1 makes channels 0 to 29 active. Inactive channels keep their bank value and never flag. `rd_nib` returns channel `rd_chan`'s bank value, or 0 for `rd_chan` of 30 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e1_mode | input | 1 | 0: 24 active channels, 1: 30 active channels |
| integ_en | input | 1 | Global three-multiframe integration enable |
| s_valid | input | 1 | Signaling sample valid |
| s_ready | output | 1 | Always 1, no back-pressure |
| s_chan | input | 5 | Channel index of the sample |
| s_nib | input | 4 | Signaling nibble of the sample |
| mf_strobe | input | 1 | One-cycle multiframe boundary pulse |
| chan_en | input | 30 | Per-channel summary enable |
| irq_en | input | 1 | Interrupt enable for the summary bit |
| clr_chg | input | 30 | Write-one-to-clear for change flags |
| clr_mf | input | 1 | Write-one-to-clear for mf_status |
| clr_cos | input | 1 | Write-one-to-clear for cos_status |
| rd_chan | input | 5 | Bank read channel |
| rd_nib | output | 4 | Bank read data |
| chg_flags | output | 30 | Sticky per-channel change flags |
| mf_status | output | 1 | Sticky multiframe boundary status |
| cos_status | output | 1 | Sticky masked summary change status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 30 channels at most, 24 in T1 mode, 4-bit nibbles and an integration depth of 3. With these values, every channel index from 0 to 31 can be driven from a 5-bit port. This puts the 24/30 mode boundary and the out-of-range read and write indices within reach. The small integration depth makes both sides of the filter cheap to test: a glitch of one or two multiframes, and a value that holds for three. It also allows random multiframe sequences to saturate the stability counters many times over.

// File: rtl/sigcos_pkg.sv
package sigcos_pkg;
  typedef enum logic {MODE_T1 = 1'b0, MODE_E1 = 1'b1} frame_mode_e;

  localparam int DEF_NCH_E1  = 30;
  localparam int DEF_NCH_T1  = 24;
  localparam int DEF_NIB_W   = 4;
  localparam int DEF_INTEG_N = 3;

  function automatic int active_chans(frame_mode_e m, int t1_n, int e1_n);
    return (m == MODE_E1) ? e1_n : t1_n;
  endfunction
endpackage

// File: rtl/sigcos_stage.sv
module sigcos_stage #(
  parameter int NCH   = 30,
  parameter int NIB_W = 4,
  parameter int CH_W  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  input  logic [CH_W-1:0]            s_chan,
  input  logic [NIB_W-1:0]           s_nib,
  input  logic [CH_W:0]              nch_act,
  output logic [NCH-1:0][NIB_W-1:0]  pend
);
  logic [NCH-1:0][NIB_W-1:0] pend_q;
  logic                      wr_ok;

  assign wr_ok = s_valid && ({1'b0, s_chan} < nch_act);
  assign pend  = pend_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        pend_q[g] <= '0;
      else if (wr_ok && (s_chan == CH_W'(g)))
        pend_q[g] <= s_nib;
    end

    // R1: an accepted in-range sample lands in its staging entry
    a_r1_stage_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && s_chan == CH_W'(g)) |=> (pend_q[g] == $past(s_nib)));
  end

  // R1: without an accepted in-range sample, staging holds
  a_r1_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(pend_q));
endmodule

// File: rtl/sigcos_chan.sv
module sigcos_chan #(
  parameter int NIB_W   = 4,
  parameter int INTEG_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             commit,
  input  logic             primed,
  input  logic             integ_en,
  input  logic [NIB_W-1:0] new_nib,
  input  logic             clr,
  output logic [NIB_W-1:0] bank_nib,
  output logic             chg_flag,
  output logic             set_pulse
);
  localparam int CNT_W = $clog2(INTEG_N + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(INTEG_N);

  logic [NIB_W-1:0] bank_q, ref_q, cand_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             chg_q, take, detect;

  always_comb begin
    if (new_nib == cand_q)
      cnt_nx = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
    else
      cnt_nx = CNT_W'(1);
    if (integ_en)
      detect = (cnt_nx == CNT_TOP) && (new_nib != ref_q);
    else
      detect = (new_nib != ref_q);
  end

  assign take      = commit && active;
  assign set_pulse = take && primed && detect;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      ref_q  <= '0;
      cand_q <= '0;
      cnt_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      if (take) begin
        bank_q <= new_nib;
        cand_q <= new_nib;
        cnt_q  <= cnt_nx;
        if (!primed || detect) ref_q <= new_nib;
      end
      chg_q <= set_pulse || (chg_q && !clr);
    end
  end

  assign bank_nib = bank_q;
  assign chg_flag = chg_q;

  // R2: bank moves only on a boundary of an active channel
  a_r2_bank_on_mf: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && active) |=> $stable(bank_q));
  // R5: flag rises only from a boundary
  a_r5_rise_at_mf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_q) |-> $past(commit && active && primed));
  // R6: clear without a boundary drops the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !commit) |=> !chg_q);
  // R9: too few stable boundaries cannot raise the flag
  a_r9_integ_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_en && commit && (cnt_q < CNT_TOP - 1'b1) && !chg_q && !clr) |=> !chg_q);
endmodule

// File: rtl/sigcos_status.sv
module sigcos_status (
  input  logic clk,
  input  logic rst_n,
  input  logic mf_strobe,
  input  logic any_en_set,
  input  logic clr_mf,
  input  logic clr_cos,
  output logic mf_q,
  output logic cos_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mf_q  <= 1'b0;
      cos_q <= 1'b0;
    end else begin
      mf_q  <= mf_strobe  || (mf_q  && !clr_mf);
      cos_q <= any_en_set || (cos_q && !clr_cos);
    end
  end

  // R3: boundary wins over clear
  a_r3_mf_set: assert property (@(posedge clk) disable iff (!rst_n)
    mf_strobe |=> mf_q);
  a_r3_mf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mf && !mf_strobe) |=> !mf_q);
  // R7: summary rises only from a boundary
  a_r7_cos_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cos_q) |-> $past(mf_strobe));
endmodule

// File: rtl/sigcos_top.sv
module sigcos_top
  import sigcos_pkg::*;
#(
  parameter int NCH_E1  = DEF_NCH_E1,
  parameter int NCH_T1  = DEF_NCH_T1,
  parameter int NIB_W   = DEF_NIB_W,
  parameter int INTEG_N = DEF_INTEG_N,
  localparam int CH_W   = $clog2(NCH_E1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e1_mode,
  input  logic              integ_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CH_W-1:0]   s_chan,
  input  logic [NIB_W-1:0]  s_nib,
  input  logic              mf_strobe,
  input  logic [NCH_E1-1:0] chan_en,
  input  logic              irq_en,
  input  logic [NCH_E1-1:0] clr_chg,
  input  logic              clr_mf,
  input  logic              clr_cos,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [NIB_W-1:0]  rd_nib,
  output logic [NCH_E1-1:0] chg_flags,
  output logic              mf_status,
  output logic              cos_status,
  output logic              irq
);
  logic [CH_W:0]                 nch_act;
  logic [NCH_E1-1:0][NIB_W-1:0]  pend, bank;
  logic [NCH_E1-1:0]             set_vec;
  logic                          primed_q;

  assign nch_act = (CH_W+1)'(active_chans(frame_mode_e'(e1_mode), NCH_T1, NCH_E1));
  assign s_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= primed_q || mf_strobe;
  end

  sigcos_stage #(.NCH(NCH_E1), .NIB_W(NIB_W), .CH_W(CH_W)) stage_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_chan(s_chan),
    .s_nib(s_nib), .nch_act(nch_act), .pend(pend));

  for (genvar g = 0; g < NCH_E1; g++) begin : g_ch
    sigcos_chan #(.NIB_W(NIB_W), .INTEG_N(INTEG_N)) chan_i (
      .clk(clk), .rst_n(rst_n),
      .active((CH_W+1)'(g) < nch_act),
      .commit(mf_strobe), .primed(primed_q), .integ_en(integ_en),
      .new_nib(pend[g]), .clr(clr_chg[g]),
      .bank_nib(bank[g]), .chg_flag(chg_flags[g]), .set_pulse(set_vec[g]));
  end

  sigcos_status status_i (
    .clk(clk), .rst_n(rst_n), .mf_strobe(mf_strobe),
    .any_en_set(|(set_vec & chan_en)), .clr_mf(clr_mf), .clr_cos(clr_cos),
    .mf_q(mf_status), .cos_q(cos_status));

  assign irq    = cos_status && irq_en;
  assign rd_nib = ({1'b0, rd_chan} < (CH_W+1)'(NCH_E1)) ? bank[rd_chan] : '0;

  // R4: the first boundary after reset sets no change flag
  a_r4_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_strobe && !primed_q) |=> (chg_flags == ($past(chg_flags) & ~$past(clr_chg))));
  // R10: channels beyond the T1 range never flag while in T1 mode
  a_r10_t1_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!e1_mode && (chg_flags[NCH_E1-1:NCH_T1] == '0)) |=> (chg_flags[NCH_E1-1:NCH_T1] == '0));
endmodule

// File: tb/sigcos_top_tb_top.sv
`timescale 1ns/1ps
module sigcos_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic e1_mode = 0, integ_en = 0, s_valid = 0, mf_strobe = 0, irq_en = 0;
  logic clr_mf = 0, clr_cos = 0;
  logic [4:0] s_chan = 0, rd_chan = 0;
  logic [3:0] s_nib = 0;
  logic [29:0] chan_en = 0, clr_chg = 0;
  logic s_ready, mf_status, cos_status, irq;
  logic [3:0] rd_nib;
  logic [29:0] chg_flags;

  logic [3:0] m_pend[30], m_bank[30], m_ref[30], m_cand[30];
  int m_cnt[30];
  logic [29:0] m_chg = 0;
  logic m_mf = 0, m_cos = 0, m_primed = 0;
  int n_vec = 0, n_fail = 0;

  always #10 clk = ~clk;

  sigcos_top dut_i (
    .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .integ_en(integ_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_chan(s_chan), .s_nib(s_nib),
    .mf_strobe(mf_strobe), .chan_en(chan_en), .irq_en(irq_en),
    .clr_chg(clr_chg), .clr_mf(clr_mf), .clr_cos(clr_cos),
    .rd_chan(rd_chan), .rd_nib(rd_nib), .chg_flags(chg_flags),
    .mf_status(mf_status), .cos_status(cos_status), .irq(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int nact = e1_mode ? 30 : 24;
    logic [29:0] setv = '0;
    logic [3:0] nw;
    int cn;
    if (mf_strobe) begin
      for (int c = 0; c < nact; c++) begin
        nw = m_pend[c];
        if (nw == m_cand[c]) cn = (m_cnt[c] >= 3) ? 3 : m_cnt[c] + 1;
        else cn = 1;
        if (m_primed && (integ_en ? (cn == 3 && nw != m_ref[c]) : (nw != m_ref[c])))
          setv[c] = 1'b1;
        if (!m_primed || setv[c]) m_ref[c] = nw;
        m_cand[c] = nw; m_cnt[c] = cn; m_bank[c] = nw;
      end
      m_primed = 1'b1;
    end
    m_chg = (m_chg & ~clr_chg) | setv;
    m_mf  = (m_mf & ~clr_mf) | mf_strobe;
    m_cos = (m_cos & ~clr_cos) | (|(setv & chan_en));
    if (s_valid && int'(s_chan) < nact) m_pend[s_chan] = s_nib;
  endtask

  task automatic check_outs();
    chk("R1 s_ready", 32'(s_ready), 32'd1);
    chk("R5 R6 chg_flags", 32'(chg_flags), 32'(m_chg));
    chk("R3 mf_status", 32'(mf_status), 32'(m_mf));
    chk("R7 cos_status", 32'(cos_status), 32'(m_cos));
    chk("R8 irq", 32'(irq), 32'(m_cos & irq_en));
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    s_valid = 0; mf_strobe = 0; clr_chg = 0; clr_mf = 0; clr_cos = 0;
    check_outs();
  endtask

  task automatic check_bank();
    for (int c = 0; c < 32; c++) begin
      rd_chan = 5'(c);
      #1;
      chk("R2 R10 rd_nib", 32'(rd_nib), (c < 30) ? 32'(m_bank[c]) : 32'd0);
    end
  endtask

  task automatic send(int ch, logic [3:0] nib);
    s_valid = 1; s_chan = 5'(ch); s_nib = nib;
    tick();
  endtask

  task automatic strobe();
    mf_strobe = 1;
    tick();
    check_bank();
  endtask

  task automatic rand_mf(int nsamp, int change_pct);
    for (int i = 0; i < nsamp; i++) begin
      int ch = $urandom % 32;
      s_valid = 1; s_chan = 5'(ch);
      s_nib = (ch < 30 && ($urandom % 100) >= change_pct) ? m_pend[ch] : 4'($urandom);
      if ($urandom % 8 == 0) clr_chg = 30'($urandom);
      if ($urandom % 8 == 0) clr_cos = 1;
      if ($urandom % 8 == 0) clr_mf = 1;
      tick();
    end
    chan_en = 30'($urandom);
    irq_en = 1'($urandom);
    mf_strobe = 1;
    if ($urandom % 4 == 0) clr_chg = 30'($urandom);
    if ($urandom % 4 == 0) clr_mf = 1;
    tick();
    check_bank();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int c = 0; c < 30; c++) begin
      m_pend[c] = 0; m_bank[c] = 0; m_ref[c] = 0; m_cand[c] = 0; m_cnt[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_outs();
    check_bank();

    // R4: load distinct values, first boundary flags nothing
    for (int c = 0; c < 30; c++) send(c, 4'(c + 1));
    chan_en = '1;
    strobe();
    chk("R4 first strobe flags", 32'(chg_flags), 32'd0);
    chk("R3 mf after first strobe", 32'(mf_status), 32'd1);
    chk("R10 ch25 untouched in T1", 32'(m_bank[25]), 32'd0);

    // R2: sample in strobe cycle belongs to next multiframe
    s_valid = 1; s_chan = 5; s_nib = 4'hA;
    strobe();
    rd_chan = 5; #1;
    chk("R2 same-cycle sample deferred", 32'(rd_nib), 32'd6);
    strobe();
    rd_chan = 5; #1;
    chk("R2 deferred sample visible", 32'(rd_nib), 32'hA);
    chk("R5 ch5 flagged", 32'(chg_flags[5]), 32'd1);

    // R6/R7: set wins over clear in the same cycle
    clr_chg = '1; clr_cos = 1; clr_mf = 1; tick();
    send(7, 4'h0);
    chan_en = 30'd0; chan_en[7] = 1; irq_en = 1;
    clr_chg[7] = 1; clr_cos = 1;
    strobe();
    chk("R6 set beats clear", 32'(chg_flags[7]), 32'd1);
    chk("R7 set beats clear", 32'(cos_status), 32'd1);
    chk("R8 irq high", 32'(irq), 32'd1);

    // R5: masked channel still flags, summary stays low
    clr_chg = '1; clr_cos = 1; tick();
    send(9, 4'hF);
    chan_en = 30'd0;
    strobe();
    chk("R5 masked channel flags", 32'(chg_flags[9]), 32'd1);
    chk("R7 masked no summary", 32'(cos_status), 32'd0);

    // R10: write to T1-inactive channel is dropped
    send(27, 4'h5);
    strobe();
    rd_chan = 27; #1;
    chk("R10 inactive channel unchanged", 32'(rd_nib), 32'd0);

    // R9: integration glitch of two boundaries, then a held value
    clr_chg = '1; tick();
    integ_en = 1;
    strobe();
    send(3, 4'hC); strobe(); strobe();
    send(3, 4'h4); strobe();
    chk("R9 two-boundary glitch ignored", 32'(chg_flags[3]), 32'd0);
    send(3, 4'hC); strobe(); strobe();
    chk("R9 not yet after two", 32'(chg_flags[3]), 32'd0);
    strobe();
    chk("R9 flag after three", 32'(chg_flags[3]), 32'd1);

    // random multiframes: T1/E1, with and without integration
    for (int k = 0; k < 60; k++) begin
      e1_mode = (k >= 30);
      integ_en = (k % 20) >= 12;
      rand_mf(6 + ($urandom % 20), (k % 3 == 0) ? 60 : 15);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule